// File: doc/BRIEF.md
# Cascaded Interval Counter Pair

This block holds two 16-bit down-counters that are programmed over an 8-bit register bus and that together form a 32-bit interval timer for interrupt generation. The first counter advances once every eight system clocks, on a tick from an internal prescaler. The second counter advances once each time the first counter reaches terminal count. Its output pulse therefore marks an interval of 8 x N1 x N2 system clocks.

Software first writes a configuration byte that names one counter. It then writes that counter's 16-bit load value as two byte writes to the counter's data offset, low byte first. The counter starts on the high byte. At terminal count it reloads the last value written and raises its output for one clock. A load value of zero stands for 65536. The count can be read back as two byte reads in the same low-then-high order.

Top module: `cascade_timer`

## Requirements
- R1: After reset both counters are stopped and hold a count of 0. Reading either data offset returns 0x00 then 0x00, and neither output pulses.
- R2: The prescaler restarts when counter 1 takes its high byte. Counter 1 then decrements once every 8 system clocks. After a load of N it pulses `ctr1_out` for the first time 8*N clocks after the high-byte write edge, and then every 8*N clocks.
- R3: Bus offsets are `bus_addr` 0 = counter 1 data, 1 = counter 2 data and 3 = configuration. At a data offset, the first write sets the low byte and the second write sets the high byte of the 16-bit load value.
- R4: A configuration write with `bus_wdata[7:6]` = 00 selects counter 1 and 01 selects counter 2. The write stops the selected counter at its present count and resets its byte sequence so that the next data access is a low byte. Codes 10 and 11 change nothing.
- R5: A counter does not count after a low-byte write alone. Its count changes only when its high byte is written or when it takes a counting step.
- R6: At terminal count a counter reloads its last complete load value and keeps running. Its output is high for exactly one system clock at that point.
- R7: Counter 2 decrements once for each `ctr1_out` pulse. `ctr2_out` is high only in a cycle in which `ctr1_out` is high, so its period is 8*N1*N2 clocks.
- R8: A load value of 0 counts as 65536. The first step after loading it gives a count of 0xFFFF.
- R9: A read at a data offset returns the live low count byte and records the high byte at that instant. The following read at that offset returns the recorded high byte. Reads and writes at an offset advance the same byte sequence.
- R10: Writes to offset 2 have no effect. Reads at offsets 2 and 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid while the read strobe is high |
| ctr1_out | output | 1 | Counter 1 terminal-count pulse |
| ctr2_out | output | 1 | Counter 2 terminal-count pulse (32-bit interval) |

## Verification
A wrong byte-sequence state shows on the very next data access. A low byte lands in the high half, which makes a pulse period roughly 256 times too long, or a read returns the recorded high byte where the low byte was due. A wrong prescaler phase or reload value moves the first or the following pulse away from the 8*N or 8*N1*N2 clock it is due on, so it is visible within one interval. A halt that fails shows up as a pulse that should not occur, or as a count that has moved on the next read. The sweep over small N1 and N2 pins both the first pulse and the period of the cascade at the exact clock.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CTR1 = 2'd0,
    SEL_CTR2 = 2'd1,
    SEL_NONE = 2'd2,
    SEL_CFG  = 2'd3
  } bus_sel_e;

  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } byte_phase_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart)          cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/count_unit.sv
module count_unit
  import timer_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [BW-1:0] wdata,
  input  logic          step,
  output logic [BW-1:0] rdata,
  output logic [2*BW-1:0] count_o,
  output logic          start_o,
  output logic          pulse_o
);
  localparam int CW = 2 * BW;
  localparam logic [CW-1:0] ONE = CW'(1);

  byte_phase_e   phase_q, phase_d;
  logic [BW-1:0] lo_stage_q, lo_stage_d;
  logic [BW-1:0] hold_q, hold_d;
  logic [CW-1:0] reload_q, reload_d;
  logic [CW-1:0] count_q, count_d;
  logic          run_q, run_d;
  logic          term;

  assign term = (count_q == ONE);

  always_comb begin
    phase_d    = phase_q;
    lo_stage_d = lo_stage_q;
    hold_d     = hold_q;
    reload_d   = reload_q;
    count_d    = count_q;
    run_d      = run_q;
    if (cfg_wr) begin
      phase_d = PH_LO;
      run_d   = 1'b0;
    end else if (data_wr) begin
      if (phase_q == PH_LO) begin
        lo_stage_d = wdata;
        phase_d    = PH_HI;
      end else begin
        reload_d = {wdata, lo_stage_q};
        count_d  = {wdata, lo_stage_q};
        run_d    = 1'b1;
        phase_d  = PH_LO;
      end
    end else begin
      if (data_rd) begin
        if (phase_q == PH_LO) begin
          hold_d  = count_q[CW-1:BW];
          phase_d = PH_HI;
        end else begin
          phase_d = PH_LO;
        end
      end
      if (run_q && step) begin
        count_d = term ? reload_q : (count_q - ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_LO;
      lo_stage_q <= '0;
      hold_q     <= '0;
      reload_q   <= '0;
      count_q    <= '0;
      run_q      <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      lo_stage_q <= lo_stage_d;
      hold_q     <= hold_d;
      reload_q   <= reload_d;
      count_q    <= count_d;
      run_q      <= run_d;
    end
  end

  assign rdata   = (phase_q == PH_LO) ? count_q[BW-1:0] : hold_q;
  assign count_o = count_q;
  assign start_o = data_wr && !cfg_wr && (phase_q == PH_HI);
  assign pulse_o = run_q && step && term;
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import timer_pkg::*;
#(
  parameter int BW       = BYTE_W,
  parameter int PRESCALE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          ctr1_out,
  output logic          ctr2_out
);
  localparam int NUM_CTR = 2;
  localparam int CW      = 2 * BW;

  logic [1:0] rst_pipe_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  bus_sel_e             sel;
  logic                 pre_tick;
  logic [NUM_CTR-1:0]   cfg_wr_v, data_wr_v, data_rd_v, step_v, start_v, pulse_v;
  logic [BW-1:0]        rdata_v [NUM_CTR];
  logic [CW-1:0]        count_v [NUM_CTR];

  assign sel = bus_sel_e'(bus_addr);

  tick_divider #(.DIV(PRESCALE)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .restart (start_v[0]),
    .tick    (pre_tick)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign cfg_wr_v[i]  = bus_wr && (sel == SEL_CFG) && (bus_wdata[BW-1:BW-2] == 2'(i));
    assign data_wr_v[i] = bus_wr && (bus_addr == 2'(i));
    assign data_rd_v[i] = bus_rd && !bus_wr && (bus_addr == 2'(i));

    if (i == 0) begin : g_first
      assign step_v[i] = pre_tick;
    end else begin : g_chain
      assign step_v[i] = pulse_v[i-1];
    end

    count_unit #(.BW(BW)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .cfg_wr  (cfg_wr_v[i]),
      .data_wr (data_wr_v[i]),
      .data_rd (data_rd_v[i]),
      .wdata   (bus_wdata),
      .step    (step_v[i]),
      .rdata   (rdata_v[i]),
      .count_o (count_v[i]),
      .start_o (start_v[i]),
      .pulse_o (pulse_v[i])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_CTR1: bus_rdata = rdata_v[0];
      SEL_CTR2: bus_rdata = rdata_v[1];
      default:  bus_rdata = '0;
    endcase
  end

  assign ctr1_out = pulse_v[0];
  assign ctr2_out = pulse_v[1];
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          out1,
  input logic          out2,
  input logic          cfg1_wr,
  input logic          load1,
  input logic          load2,
  input logic [CW-1:0] cnt1,
  input logic [CW-1:0] cnt2
);
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_OUT1_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    out1 |-> tick); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out1 |=> !out1); // R6
  AST_CASCADE_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
    out2 |-> out1); // R7
  AST_HALT_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg1_wr |=> !out1); // R4
  AST_CNT1_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load1) |=> $stable(cnt1)); // R5
  AST_CNT2_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!out1 && !load2) |=> $stable(cnt2)); // R7
endmodule

bind cascade_timer timer_checker #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .tick    (pre_tick),
  .out1    (ctr1_out),
  .out2    (ctr2_out),
  .cfg1_wr (cfg_wr_v[0]),
  .load1   (start_v[0]),
  .load2   (start_v[1]),
  .cnt1    (count_v[0]),
  .cnt2    (count_v[1])
);

// File: tb/sim_cascade_timer.sv
`timescale 1ns/1ps
module sim_cascade_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       out1, out2;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cascade_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .ctr1_out(out1), .ctr2_out(out2)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All bus tasks start at a negedge and end at the next negedge.
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic load(input logic [1:0] c, input logic [15:0] val);
    bus_write(2'd3, {c, 6'b0});
    bus_write(c, val[7:0]);
    bus_write(c, val[15:8]);
  endtask

  task automatic read16(input logic [1:0] c, output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_read(c, lo);
    bus_read(c, hi);
    v = {hi, lo};
  endtask

  // k counts negedges; the caller's current negedge is k0.
  task automatic wait_pulse(input bit which, input int k0, input int limit, output int k);
    k = k0;
    while (!(which ? out2 : out1) && k < limit) begin
      @(negedge clk);
      k++;
    end
    if (!(which ? out2 : out1)) k = -1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int k;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    read16(2'd0, v); check(v == 16'h0, "R1 ctr1 reset count", v, 0);
    read16(2'd1, v); check(v == 16'h0, "R1 ctr2 reset count", v, 0);
    seen = 0;
    repeat (40) begin if (out1 || out2) seen = 1; @(negedge clk); end
    check(!seen, "R1 no pulse after reset", seen, 0);

    // R3/R9: byte order on load and readback, snapshot of high byte
    load(2'd0, 16'h1234);
    read16(2'd0, v); check(v == 16'h1234, "R3 R9 readback of load", v, 16'h1234);
    repeat (6) @(negedge clk);
    read16(2'd0, v); check(v == 16'h1233, "R2 R9 one step after 8 clocks", v, 16'h1233);
    bus_write(2'd3, 8'h00);

    // R8: zero load means 65536
    load(2'd0, 16'h0000);
    repeat (8) @(negedge clk);
    read16(2'd0, v); check(v == 16'hFFFF, "R8 zero load wraps", v, 16'hFFFF);
    bus_write(2'd3, 8'h00);

    // R2/R6: counter 1 period and single-cycle pulse
    load(2'd0, 16'd3);
    wait_pulse(1'b0, 1, 100, k); check(k == 24, "R2 first ctr1 pulse", k, 24);
    @(negedge clk); check(!out1, "R6 pulse one clock", out1, 0);
    wait_pulse(1'b0, 1, 100, k); check(k == 24, "R6 reload period", k, 24);
    bus_write(2'd3, 8'h00);

    // R4: halt at present count
    load(2'd0, 16'd5);
    repeat (19) @(negedge clk);
    bus_write(2'd3, 8'h00);
    seen = 0;
    repeat (50) begin if (out1) seen = 1; @(negedge clk); end
    check(!seen, "R4 halted no pulse", seen, 0);
    read16(2'd0, v); check(v == 16'd3, "R4 halted count held", v, 3);

    // R5: low byte alone does not start; R4 config resets byte order
    bus_write(2'd3, 8'h00);
    bus_write(2'd0, 8'h09);
    seen = 0;
    repeat (50) begin if (out1) seen = 1; @(negedge clk); end
    check(!seen, "R5 no start on low byte", seen, 0);
    bus_write(2'd3, 8'h00);
    read16(2'd0, v); check(v == 16'd3, "R5 count unchanged by low byte", v, 3);
    bus_write(2'd3, 8'h00);
    bus_write(2'd0, 8'h03);
    bus_write(2'd0, 8'h00);
    wait_pulse(1'b0, 1, 100, k); check(k == 24, "R4 byte order reset by config", k, 24);
    bus_write(2'd3, 8'h00);

    // R10 and R4 unused codes: ignored accesses while running
    load(2'd0, 16'd2);
    bus_write(2'd3, 8'h80);
    bus_write(2'd2, 8'h55);
    bus_write(2'd3, 8'hC0);
    wait_pulse(1'b0, 4, 100, k); check(k == 16, "R10 R4 ignored writes keep timing", k, 16);
    bus_read(2'd2, v[7:0]); check(v[7:0] == 8'h00, "R10 read offset 2", v[7:0], 0);
    bus_read(2'd3, v[7:0]); check(v[7:0] == 8'h00, "R10 read offset 3", v[7:0], 0);
    bus_write(2'd3, 8'h00);

    // R7: sweep of the cascade over small load values
    for (int n = 1; n <= 6; n++) begin
      for (int m = 1; m <= 4; m++) begin
        int lim;
        lim = 8 * n * m + 10;
        load(2'd1, 16'(m));
        load(2'd0, 16'(n));
        wait_pulse(1'b1, 1, lim, k);
        check(k == 8 * n * m, $sformatf("R7 first ctr2 pulse n=%0d m=%0d", n, m), k, 8 * n * m);
        check(out1 == 1'b1, "R7 ctr2 pulse coincides with ctr1", out1, 1);
        @(negedge clk);
        check(!out2, "R6 ctr2 pulse one clock", out2, 0);
        wait_pulse(1'b1, 1, lim, k);
        check(k == 8 * n * m, $sformatf("R7 ctr2 period n=%0d m=%0d", n, m), k, 8 * n * m);
        bus_write(2'd3, 8'h00);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule